// File: doc/BRIEF.md
# Synchronous Bus Write Pacer

This block drives bytes onto a parallel peripheral bus in synchronous transfer mode. Each accepted byte is placed on nine data lines: eight data bits and an odd-parity bit. A strobe (REQ) then pulses high for a fixed time. The pacer does not wait for the target to answer each strobe. It keeps issuing bytes at a rate set by a programmed period, until the number of strobes not yet answered on the acknowledge line reaches a window derived from the negotiated offset. Each acknowledge edge from the target returns one credit.

A byte source feeds the pacer through a valid/ready handshake. Two configuration values, an offset and a period, are held steady by the surrounding logic. The pacer takes a snapshot of them only while it is fully idle, so a change applies from the next transfer onward. A completion flag reports when nothing is in flight, every byte has been acknowledged and the acknowledge line has been released. This is the point at which the bus may be handed to other logic.

Top module: `sync_req_pacer`

## Requirements
- R1: After reset, `bus_req` is 0, `bus_data` is 0, `all_acked` is 1 and `in_ready` is 1.
- R2: The data setup interval is d0+1 cycles, counted from the first cycle a new byte is on `bus_data` to the first cycle `bus_req` is high. Here d0 = 3 when `cfg_period` <= 25 and d0 = 6 otherwise.
- R3: `bus_req` stays high for d1+1 cycles, where d1 = 5 when `cfg_period` <= 25 and d1 = 12 otherwise.
- R4: The trailing delay is d2, computed as B = floor(`cfg_period`/2) and d2 = B - d0 - d1 - 3, limited to the range 0..15. When bytes are offered without pause, successive `bus_req` rises are d0+d1+d2+3 cycles apart.
- R5: While a byte is in flight, `bus_data[7:0]` carries the byte and `bus_data[8]` makes the number of ones across all nine bits odd. `bus_data` does not change while `bus_req` is high, and it is 0 when the pacer is idle.
- R6: The window W is (4-P)*D. D is 1 for offsets up to 4, 2 for offsets 5..8 and 4 for larger offsets. P is min(3, 5-offset) for offsets up to 4, min(3, 5-offset/2) for 5..8, min(3, 5-offset/4) for 9..16, and 0 above 16 (integer division). When W strobes are unacknowledged, `in_ready` is 0 and no further strobe is issued.
- R7: `ack_in` passes through a two-stage synchroniser. Each 0-to-1 transition frees exactly one credit, however long the line is then held high.
- R8: `all_acked` is 1 exactly when no byte is in flight, the unacknowledged count is 0 and the synchronised acknowledge is low. It rises on the second clock edge after `ack_in` falls.
- R9: `cfg_offset` and `cfg_period` are sampled only while `all_acked` conditions hold. Changes made during a transfer have no effect until the pacer is next fully idle.
- R10: Every accepted byte produces exactly one strobe, and strobes follow the order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one delay unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered by the source |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Byte taken on this edge when in_valid is high |
| ack_in | input | 1 | Target acknowledge, active high, asynchronous |
| cfg_offset | input | OFS_W | Negotiated offset in bytes (1..128) |
| cfg_period | input | PER_W | Transfer period in 4 ns units |
| bus_data | output | 9 | Parity bit [8] and data [7:0] |
| bus_req | output | 1 | Strobe, active high |
| all_acked | output | 1 | Idle with every byte acknowledged |

## Verification
A byte taken on edge n appears on `bus_data` right after that edge. The strobe follows d0+1 edges later, falls after another d1+1, and the next byte follows d2+1 edges after that. An acknowledge edge lowers the unacknowledged count on the third clock edge after it is raised. `all_acked` follows a released acknowledge on the second edge. The bench samples 1 ns after each rising edge and compares differences of sample indices against these counts, computed from the period value. Stall and credit checks wait out a full window of byte times before counting strobes, so they do not depend on exact edge placement.

// File: rtl/sync_req_pacer.sv
module sync_req_pacer #(
  parameter int OFS_W = 8,
  parameter int PER_W = 8,
  parameter int CRD_W = 5,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             ack_in,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [PER_W-1:0] cfg_period,
  output logic [8:0]       bus_data,
  output logic             bus_req,
  output logic             all_acked
);
  localparam logic [DLY_W-1:0] DLY_MAX = '1;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_TRAIL} ph_t;

  ph_t              ph;
  logic [DLY_W-1:0] cnt;
  logic [7:0]       byte_q;
  logic [CRD_W-1:0] out_q, win_q, win_n, win_e;
  logic [DLY_W-1:0] d0_q, d1_q, d2_q, d0_n, d1_n, d2_n, d0_e;
  logic [2:0]       ack_s;
  logic             idle_all, take, ack_rise, fast;

  assign fast = cfg_period <= PER_W'(25);
  assign d0_n = fast ? DLY_W'(3) : DLY_W'(6);
  assign d1_n = fast ? DLY_W'(5) : DLY_W'(12);

  always_comb begin
    logic [PER_W:0] budget, need;
    budget = {1'b0, cfg_period} >> 1;
    need   = (PER_W+1)'(d0_n) + (PER_W+1)'(d1_n) + (PER_W+1)'(3);
    if (budget < need)                          d2_n = '0;
    else if (budget - need > (PER_W+1)'(DLY_MAX)) d2_n = DLY_MAX;
    else                                         d2_n = DLY_W'(budget - need);
  end

  always_comb begin
    logic [OFS_W-1:0] pre_raw;
    logic [1:0]       pre;
    logic [2:0]       div;
    if (cfg_offset <= OFS_W'(4)) begin
      div = 3'd1; pre_raw = OFS_W'(5) - cfg_offset;
    end else if (cfg_offset <= OFS_W'(8)) begin
      div = 3'd2; pre_raw = OFS_W'(5) - (cfg_offset >> 1);
    end else if (cfg_offset <= OFS_W'(16)) begin
      div = 3'd4; pre_raw = OFS_W'(5) - (cfg_offset >> 2);
    end else begin
      div = 3'd4; pre_raw = '0;
    end
    pre   = (pre_raw > OFS_W'(3)) ? 2'd3 : pre_raw[1:0];
    win_n = (CRD_W'(4) - CRD_W'(pre)) * CRD_W'(div);
  end

  assign idle_all = (ph == PH_IDLE) && (out_q == '0);
  assign win_e    = idle_all ? win_n : win_q;
  assign d0_e     = idle_all ? d0_n  : d0_q;
  assign in_ready = ((ph == PH_IDLE) || (ph == PH_TRAIL && cnt == '0)) && (out_q < win_e);
  assign take     = in_valid && in_ready;
  assign ack_rise = ack_s[1] && !ack_s[2];

  assign bus_req   = (ph == PH_STROBE);
  assign bus_data  = (ph == PH_IDLE) ? 9'd0 : {~^byte_q, byte_q};
  assign all_acked = idle_all && !ack_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_s <= '0;
      out_q <= '0;
      win_q <= CRD_W'(1);
      d0_q  <= DLY_W'(3);
      d1_q  <= DLY_W'(5);
      d2_q  <= '0;
    end else begin
      ack_s <= {ack_s[1:0], ack_in};
      out_q <= out_q + CRD_W'(take) - CRD_W'(ack_rise && out_q != '0);
      if (idle_all) begin
        win_q <= win_n;
        d0_q  <= d0_n;
        d1_q  <= d1_n;
        d2_q  <= d2_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      byte_q <= '0;
    end else begin
      if (take) byte_q <= in_data;
      unique case (ph)
        PH_IDLE:
          if (take) begin ph <= PH_SETUP; cnt <= d0_e; end
        PH_SETUP:
          if (cnt == '0) begin ph <= PH_STROBE; cnt <= d1_q; end
          else cnt <= cnt - 1'b1;
        PH_STROBE:
          if (cnt == '0) begin ph <= PH_TRAIL; cnt <= d2_q; end
          else cnt <= cnt - 1'b1;
        PH_TRAIL:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (take) begin ph <= PH_SETUP; cnt <= d0_q; end
          else ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

module sync_req_pacer_chk #(
  parameter int CRD_W = 5,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic [8:0]       bus_data,
  input logic             in_ready,
  input logic             all_acked,
  input logic             idle_all,
  input logic [CRD_W-1:0] out_q,
  input logic [CRD_W-1:0] win_q,
  input logic [DLY_W-1:0] d2_q
);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_q <= win_q);

  assert_data_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(bus_data));

  assert_ready_not_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bus_req);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    all_acked |-> (!bus_req && bus_data == 9'd0));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_all && $past(!idle_all)) |-> ($stable(win_q) && $stable(d2_q)));
endmodule

bind sync_req_pacer sync_req_pacer_chk #(.CRD_W(CRD_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_data(bus_data),
  .in_ready(in_ready), .all_acked(all_acked), .idle_all(idle_all),
  .out_q(out_q), .win_q(win_q), .d2_q(d2_q)
);

// File: tb/sim_sync_req_pacer.sv
`timescale 1ns/1ps
module sim_sync_req_pacer;
  logic       clk = 0, rst_n = 0;
  logic       in_valid = 0, ack_in = 0;
  logic [7:0] in_data = 0;
  logic [7:0] cfg_offset = 8'd20, cfg_period = 8'd10;
  logic       in_ready, bus_req, all_acked;
  logic [8:0] bus_data;

  sync_req_pacer u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ack_in(ack_in), .cfg_offset(cfg_offset), .cfg_period(cfg_period),
    .bus_data(bus_data), .bus_req(bus_req), .all_acked(all_acked));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, seed = 0;
  int feed_left = 0, feed_idx = 0, nreq = 0, tick = 0;
  int first_data = -1, first_rise = -1, last_rise = -1, prev_rise = -1, last_high = -1;
  bit fire_pend = 0, prev_req = 0, prev_nz = 0;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 53 + seed) & 255);
  endfunction
  function automatic int e_d0(int p); return (p <= 25) ? 3 : 6; endfunction
  function automatic int e_d1(int p); return (p <= 25) ? 5 : 12; endfunction
  function automatic int e_d2(int p);
    int v = p / 2 - e_d0(p) - e_d1(p) - 3;
    return (v < 0) ? 0 : (v > 15) ? 15 : v;
  endfunction
  function automatic int e_win(int o);
    int d, pr;
    if (o <= 4)       begin d = 1; pr = 5 - o; end
    else if (o <= 8)  begin d = 2; pr = 5 - o / 2; end
    else if (o <= 16) begin d = 4; pr = 5 - o / 4; end
    else              begin d = 4; pr = 0; end
    if (pr > 3) pr = 3;
    return (4 - pr) * d;
  endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (fire_pend) begin feed_idx++; feed_left--; end
    in_valid  = feed_left > 0;
    in_data   = pat(feed_idx);
    fire_pend = in_valid && in_ready;
    tick++;
    if (bus_req && !prev_req) begin
      check(bus_data === {~^pat(nreq), pat(nreq)}, "R5 R10 data at strobe", int'(bus_data),
            int'({~^pat(nreq), pat(nreq)}));
      nreq++;
      prev_rise = last_rise;
      last_rise = tick;
      if (first_rise < 0) first_rise = tick;
    end
    if (!bus_req && prev_req) last_high = tick - last_rise;
    if (bus_data != 0 && !prev_nz && first_data < 0) first_data = tick;
    prev_req = bus_req;
    prev_nz  = bus_data != 0;
  end

  task automatic start(int n, int s);
    seed = s; feed_idx = 0; nreq = 0;
    first_data = -1; first_rise = -1; last_rise = -1; prev_rise = -1; last_high = -1;
    feed_left = n;
  endtask

  task automatic acks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ack_in = 1;
      repeat (3) @(negedge clk);
      ack_in = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic wait_idle(string rq);
    for (int i = 0; i < 3000; i++) begin
      if (all_acked) break;
      @(negedge clk);
    end
    check(all_acked === 1'b1, rq, int'(all_acked), 1);
    check(bus_data === 9'd0, "R5 idle bus", int'(bus_data), 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bus_req === 1'b0, "R1 req", int'(bus_req), 0);
    check(bus_data === 9'd0, "R1 data", int'(bus_data), 0);
    check(all_acked === 1'b1, "R1 all_acked", int'(all_acked), 1);
    check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R2 R3 R4: period sweep across fast, slow and both clamps
    for (int p = 8; p <= 80; p++) begin
      int iv;
      @(negedge clk);
      cfg_offset = 8'd20; cfg_period = 8'(p);
      iv = e_d0(p) + e_d1(p) + e_d2(p) + 3;
      @(negedge clk);
      start(3, p);
      repeat (3 * iv + 20) @(negedge clk);
      check(nreq == 3, "R10 strobe count", nreq, 3);
      check(first_rise - first_data == e_d0(p) + 1, "R2 setup", first_rise - first_data, e_d0(p) + 1);
      check(last_high == e_d1(p) + 1, "R3 strobe width", last_high, e_d1(p) + 1);
      check(last_rise - prev_rise == iv, "R4 interval", last_rise - prev_rise, iv);
      check(all_acked === 1'b0, "R8 pending", int'(all_acked), 0);
      acks(3);
      wait_idle("R8 after acks");
    end

    // R6 R7: window sweep
    for (int i = 1; i <= 42; i++) begin
      int o, w;
      o = (i <= 40) ? i : (i == 41) ? 100 : 128;
      w = e_win(o);
      @(negedge clk);
      cfg_offset = 8'(o); cfg_period = 8'd10;
      @(negedge clk);
      start(w + 1, i * 7);
      repeat ((w + 1) * 11 + 40) @(negedge clk);
      check(nreq == w, "R6 stall at window", nreq, w);
      check(in_ready === 1'b0, "R6 ready low when full", int'(in_ready), 0);
      acks(1);
      repeat (30) @(negedge clk);
      check(nreq == w + 1, "R7 one credit freed", nreq, w + 1);
      acks(w);
      wait_idle("R8 window drain");
    end

    // R7 R8: long acknowledge counts once; release timing
    @(negedge clk);
    cfg_offset = 8'd20; cfg_period = 8'd10;
    @(negedge clk);
    start(2, 99);
    repeat (60) @(negedge clk);
    check(nreq == 2, "R10 two strobes", nreq, 2);
    ack_in = 1;
    repeat (40) @(negedge clk);
    ack_in = 0;
    repeat (10) @(negedge clk);
    check(all_acked === 1'b0, "R7 held ack counted once", int'(all_acked), 0);
    ack_in = 1;
    repeat (6) @(negedge clk);
    check(all_acked === 1'b0, "R8 low while ack high", int'(all_acked), 0);
    ack_in = 0;
    @(negedge clk);
    check(all_acked === 1'b0, "R8 one edge after release", int'(all_acked), 0);
    @(negedge clk);
    check(all_acked === 1'b1, "R8 two edges after release", int'(all_acked), 1);

    // R9: configuration change during a transfer is ignored
    @(negedge clk);
    cfg_offset = 8'd20; cfg_period = 8'd60;
    @(negedge clk);
    start(3, 5);
    while (first_rise < 0) @(negedge clk);
    cfg_period = 8'd10; cfg_offset = 8'd1;
    repeat (120) @(negedge clk);
    check(nreq == 3, "R9 window kept", nreq, 3);
    check(last_rise - prev_rise == 30, "R9 period kept", last_rise - prev_rise, 30);
    acks(3);
    wait_idle("R9 drain");
    start(3, 11);
    repeat (80) @(negedge clk);
    check(nreq == 1, "R9 new window applied", nreq, 1);
    check(last_high == 6, "R9 new width applied", last_high, 6);
    acks(1);
    repeat (40) @(negedge clk);
    acks(1);
    repeat (40) @(negedge clk);
    acks(1);
    wait_idle("R9 final drain");
    check(nreq == 3, "R10 all sent", nreq, 3);

    summary();
  end
endmodule